// File: doc/BRIEF.md
# Page Access Permission Checker

The checker sits after a page table walk. For each translated access it takes the kind of access (load, store, instruction fetch, or a combined store-and-fetch), whether the access comes from user mode, the 3-bit access field and the modified bit of the final page table entry, and the virtual address. From these it produces a fault code and the read/write/execute rights that may be granted for the page. One cycle after each accepted request, the result appears together with a single-cycle valid strobe.

A fault also updates a fault status register and a fault address register, which are visible on plain read ports. Reading the status register consumes it, so it is zero on the next cycle. If a second fault arrives before the first was read, the register marks overflow. In no-fault mode, permission faults from user accesses are suppressed. Write rights are always withheld from a page whose modified bit is clear, so the first store to that page comes back through the walker, which can then set the bit.

The request side is a valid-only stream. The checker accepts a request on every cycle and applies no back-pressure. The response strobe cannot be stalled, so the consumer must take each response in the cycle it is shown.

Top module: `page_perm_check`

## Requirements
- R1: The access index is {store, fetch, supervisor}, with bit 2 the store flag, bit 1 the fetch flag and bit 0 equal to 1 for a non-user access. A fault records the index in status bits 7:5.
- R2: Each request with `req_valid` high gives exactly one `resp_valid` pulse on the next cycle. The fault code carried with it is 0 (allowed), 8 (protection) or 12 (privilege).
- R3: A user access to field 6 or 7 gets fault code 12. User rights are: field 5 read only, fields 6 and 7 none, 0 read, 1 read/write, 2 read/exec, 3 all, 4 exec.
- R4: Supervisor rights are: 0 read, 1 read/write, 2 read/exec, 3 all, 4 exec, 5 read/write, 6 read/exec, 7 all. Rights are encoded as bit 0 read, bit 1 write, bit 2 exec. A load needs read, a fetch needs exec and a store needs write; a combined store and fetch needs both. A missing right gives code 8.
- R5: When `nofault_en` is high, a user access reports code 0 and leaves both registers unchanged. A supervisor access still faults.
- R6: `resp_rights` bit 1 (write) is 0 whenever the request's modified bit was 0.
- R7: A faulting response carries `resp_rights` equal to 0.
- R8: On a fault, the status register gets (index << 5) | code | 2, where bit 1 is the address-valid flag. The fault address register gets the address with its low 12 bits cleared.
- R9: A fault that finds the status register nonzero and not being read that cycle first resets it to 1 (overflow, bit 0) and then ORs in the new fields.
- R10: `fsr_rdata` shows the current status. A cycle with `fsr_rd` high clears it at the next edge. When a fault falls in the same cycle as a read, the new status holds only the new fault, with no overflow.
- R11: After reset, `resp_valid`, the status register and the address register are 0.
- R12: Requests are accepted on every cycle with no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | Access writes |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is from user mode |
| req_field | input | 3 | Access-control field of the entry |
| req_modified | input | 1 | Modified bit of the entry |
| nofault_en | input | 1 | No-fault mode control |
| req_vaddr | input | VA_W | Virtual address of the access |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_code | output | 4 | Fault code: 0, 8 or 12 |
| resp_rights | output | 3 | Granted rights {exec, write, read} |
| fsr_rd | input | 1 | Read strobe that clears the status register |
| fsr_rdata | output | 8 | Fault status register |
| far_rdata | output | VA_W | Fault address register |

## Verification
A status read and a new fault can fall in the same cycle. The result then depends on which of the two the register honours: the read is meant to consume the old value, and the fault must not be marked as overflow. The bench provokes this directly, after leaving two unread faults in place. Random stimulus issues reads a quarter of the time alongside frequent faults, so the same collision recurs many times. A bench model of the status register judges every cycle: it checks the value shown during the read and the value that follows.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;
  localparam int FIELD_W   = 3;
  localparam int IDX_W     = 3;
  localparam int CODE_W    = 4;
  localparam int RIGHTS_W  = 3;
  localparam int IDX_SHIFT = 5;
  localparam int FSR_W     = IDX_SHIFT + IDX_W;

  localparam logic [RIGHTS_W-1:0] RT_R = 3'b001;
  localparam logic [RIGHTS_W-1:0] RT_W = 3'b010;
  localparam logic [RIGHTS_W-1:0] RT_X = 3'b100;

  localparam logic [CODE_W-1:0] CODE_OK   = 4'd0;
  localparam logic [CODE_W-1:0] CODE_PROT = 4'd8;
  localparam logic [CODE_W-1:0] CODE_PRIV = 4'd12;

  localparam logic [FSR_W-1:0] FSR_OVF   = 8'h01;
  localparam logic [FSR_W-1:0] FSR_ADDRV = 8'h02;
endpackage

// File: rtl/page_perm_lookup.sv
module page_perm_lookup
  import page_perm_pkg::*;
(
  input  logic [IDX_W-1:0]    acc_idx,
  input  logic [FIELD_W-1:0]  field,
  output logic [CODE_W-1:0]   code,
  output logic [RIGHTS_W-1:0] perm
);
  logic is_user, is_store, is_fetch;
  logic [RIGHTS_W-1:0] need;

  assign is_user  = ~acc_idx[0];
  assign is_fetch = acc_idx[1];
  assign is_store = acc_idx[2];

  always_comb begin
    unique case (field)
      3'd0: perm = RT_R;
      3'd1: perm = RT_R | RT_W;
      3'd2: perm = RT_R | RT_X;
      3'd3: perm = RT_R | RT_W | RT_X;
      3'd4: perm = RT_X;
      3'd5: perm = is_user ? RT_R : (RT_R | RT_W);
      3'd6: perm = is_user ? '0 : (RT_R | RT_X);
      default: perm = is_user ? '0 : (RT_R | RT_W | RT_X);
    endcase
  end

  assign need = (is_fetch ? RT_X : '0) | (is_store ? RT_W : '0) |
                ((is_store | is_fetch) ? '0 : RT_R);

  always_comb begin
    if (is_user && field[2:1] == 2'b11) code = CODE_PRIV;
    else if ((need & ~perm) != '0)      code = CODE_PROT;
    else                                code = CODE_OK;
  end
endmodule

// File: rtl/page_perm_status.sv
module page_perm_status
  import page_perm_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_evt,
  input  logic [IDX_W-1:0]  fault_idx,
  input  logic [CODE_W-1:0] fault_code,
  input  logic [VA_W-1:0]   fault_va,
  input  logic              fsr_rd,
  output logic [FSR_W-1:0]  fsr_q,
  output logic [VA_W-1:0]   far_q
);
  localparam int PFN_W = VA_W - PAGE_BITS;

  logic [FSR_W-1:0] base;
  logic [FSR_W-1:0] fields;

  assign base   = (fsr_q != '0 && !fsr_rd) ? FSR_OVF : '0;
  assign fields = {fault_idx, {IDX_SHIFT{1'b0}}} | FSR_W'(fault_code) | FSR_ADDRV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (fault_evt) begin
      fsr_q <= base | fields;
      far_q <= {fault_va[VA_W-1 -: PFN_W], {PAGE_BITS{1'b0}}};
    end else if (fsr_rd) begin
      fsr_q <= '0;
    end
  end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import page_perm_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_store,
  input  logic                req_fetch,
  input  logic                req_user,
  input  logic [FIELD_W-1:0]  req_field,
  input  logic                req_modified,
  input  logic                nofault_en,
  input  logic [VA_W-1:0]     req_vaddr,
  output logic                resp_valid,
  output logic [CODE_W-1:0]   resp_code,
  output logic [RIGHTS_W-1:0] resp_rights,
  input  logic                fsr_rd,
  output logic [FSR_W-1:0]    fsr_rdata,
  output logic [VA_W-1:0]     far_rdata
);
  logic [IDX_W-1:0]    acc_idx;
  logic [CODE_W-1:0]   raw_code;
  logic [RIGHTS_W-1:0] raw_perm;
  logic                fault_now;
  logic [RIGHTS_W-1:0] grant;

  assign acc_idx = {req_store, req_fetch, ~req_user};

  page_perm_lookup u_lookup (
    .acc_idx (acc_idx),
    .field   (req_field),
    .code    (raw_code),
    .perm    (raw_perm)
  );

  assign fault_now = req_valid && (raw_code != CODE_OK) && !(nofault_en && req_user);
  assign grant     = raw_perm & ~(req_modified ? '0 : RT_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_code   <= '0;
      resp_rights <= '0;
    end else begin
      resp_valid  <= req_valid;
      resp_code   <= fault_now ? raw_code : CODE_OK;
      resp_rights <= fault_now ? '0 : grant;
    end
  end

  page_perm_status #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_evt  (fault_now),
    .fault_idx  (acc_idx),
    .fault_code (raw_code),
    .fault_va   (req_vaddr),
    .fsr_rd     (fsr_rd),
    .fsr_q      (fsr_rdata),
    .far_q      (far_rdata)
  );
endmodule

// File: rtl/page_perm_check_chk.sv
module page_perm_check_chk
  import page_perm_pkg::*;
#(
  parameter int VA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_user,
  input logic [FIELD_W-1:0]  req_field,
  input logic                req_modified,
  input logic                nofault_en,
  input logic                resp_valid,
  input logic [CODE_W-1:0]   resp_code,
  input logic [RIGHTS_W-1:0] resp_rights,
  input logic                fsr_rd,
  input logic [FSR_W-1:0]    fsr_rdata
);
  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  // R12
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  // R3
  user_priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_user && req_field[2:1] == 2'b11 && !nofault_en |=> resp_code == CODE_PRIV);
  // R6
  no_write_unmodified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_modified |=> !resp_rights[1]);
  // R7
  fault_no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_code != CODE_OK |-> resp_rights == '0);
  // R8
  fault_sets_addrv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_code != CODE_OK |-> fsr_rdata[1]);
  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsr_rd && !req_valid |=> fsr_rdata == '0);
  // R9
  overflow_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_code != CODE_OK && $past(fsr_rdata != '0 && !fsr_rd) |-> fsr_rdata[0]);
endmodule

bind page_perm_check page_perm_check_chk #(.VA_W(VA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_user     (req_user),
  .req_field    (req_field),
  .req_modified (req_modified),
  .nofault_en   (nofault_en),
  .resp_valid   (resp_valid),
  .resp_code    (resp_code),
  .resp_rights  (resp_rights),
  .fsr_rd       (fsr_rd),
  .fsr_rdata    (fsr_rdata)
);

// File: tb/page_perm_check_test.sv
`timescale 1ns/1ps
module page_perm_check_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_fetch = 0, req_user = 0;
  logic [2:0] req_field = '0;
  logic req_modified = 0, nofault_en = 0, fsr_rd = 0;
  logic [31:0] req_vaddr = '0;
  logic resp_valid;
  logic [3:0] resp_code;
  logic [2:0] resp_rights;
  logic [7:0] fsr_rdata;
  logic [31:0] far_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0]  fsr_m = '0;
  logic [31:0] far_m = '0;

  always #10 clk = ~clk;

  page_perm_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_fetch(req_fetch), .req_user(req_user), .req_field(req_field),
    .req_modified(req_modified), .nofault_en(nofault_en), .req_vaddr(req_vaddr),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_rights(resp_rights),
    .fsr_rd(fsr_rd), .fsr_rdata(fsr_rdata), .far_rdata(far_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // rights {x,w,r} per the R3/R4 tables
  function automatic logic [2:0] m_perm(input bit user, input logic [2:0] f);
    case (f)
      3'd0: return 3'b001;
      3'd1: return 3'b011;
      3'd2: return 3'b101;
      3'd3: return 3'b111;
      3'd4: return 3'b100;
      3'd5: return user ? 3'b001 : 3'b011;
      3'd6: return user ? 3'b000 : 3'b101;
      default: return user ? 3'b000 : 3'b111;
    endcase
  endfunction

  function automatic logic [3:0] m_code(input bit st, input bit fe, input bit user, input logic [2:0] f);
    logic [2:0] need;
    if (user && f >= 3'd6) return 4'd12;
    need = {fe, st, !(st || fe)};
    return ((need & ~m_perm(user, f)) != 0) ? 4'd8 : 4'd0;
  endfunction

  task automatic do_req(input bit v, input bit st, input bit fe, input bit us,
                        input logic [2:0] fl, input bit md, input bit nf,
                        input logic [31:0] va, input bit rd, input string tag);
    logic [3:0] code, e_code;
    logic [2:0] e_r;
    bit fault;
    req_valid = v; req_store = st; req_fetch = fe; req_user = us;
    req_field = fl; req_modified = md; nofault_en = nf; req_vaddr = va; fsr_rd = rd;
    #1;
    check(fsr_rdata === fsr_m, "R1 R8 status", 32'(fsr_rdata), 32'(fsr_m));
    check(far_rdata === far_m, "R8 address", far_rdata, far_m);
    code   = m_code(st, fe, us, fl);
    fault  = v && code != 0 && !(nf && us);
    e_code = fault ? code : 4'd0;
    e_r    = fault ? 3'b000 : (m_perm(us, fl) & (md ? 3'b111 : 3'b101));
    if (fault) begin
      fsr_m = ((fsr_m != 0 && !rd) ? 8'h01 : 8'h00) | {st, fe, ~us, 5'b0} | {4'b0, code} | 8'h02;
      far_m = {va[31:12], 12'h000};
    end else if (rd) begin
      fsr_m = 8'h00;
    end
    @(posedge clk);
    @(negedge clk);
    check(resp_valid === v, "R12 R2 strobe", 32'(resp_valid), 32'(v));
    if (v) begin
      check(resp_code === e_code, {tag, " code"}, 32'(resp_code), 32'(e_code));
      check(resp_rights === e_r, {tag, " rights"}, 32'(resp_rights), 32'(e_r));
    end
    req_valid = 0; fsr_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(resp_valid === 1'b0, "R11 resp_valid", 32'(resp_valid), 0);
    check(fsr_rdata === 8'h00, "R11 status", 32'(fsr_rdata), 0);
    check(far_rdata === 32'h0, "R11 address", far_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_req(1, 1, 0, 0, 3'd5, 0, 0, 32'h1000_0123, 0, "R6 super store unmodified");
    do_req(1, 1, 0, 0, 3'd5, 1, 0, 32'h1000_0123, 0, "R4 super store field5");
    do_req(1, 0, 0, 1, 3'd5, 1, 0, 32'h2000_0456, 0, "R3 user load field5");
    do_req(1, 0, 1, 1, 3'd6, 1, 0, 32'h3456_7abc, 0, "R3 R7 user fetch field6");
    check(fsr_rdata === 8'h4E, "R1 R8 status after privilege fault", 32'(fsr_rdata), 32'h4E);
    check(far_rdata === 32'h3456_7000, "R8 page aligned address", far_rdata, 32'h3456_7000);
    do_req(0, 0, 0, 0, 3'd0, 0, 0, 32'h0, 1, "R10 idle read");
    check(fsr_rdata === 8'h00, "R10 cleared after read", 32'(fsr_rdata), 0);
    do_req(1, 0, 0, 1, 3'd7, 1, 1, 32'h4000_0000, 0, "R5 user nofault field7");
    check(fsr_rdata === 8'h00, "R5 status untouched", 32'(fsr_rdata), 0);
    do_req(1, 1, 0, 0, 3'd0, 1, 1, 32'h5000_0fff, 0, "R5 super still faults");
    check(fsr_rdata === 8'hAA, "R5 R8 supervisor fault recorded", 32'(fsr_rdata), 32'hAA);
    do_req(1, 1, 0, 1, 3'd0, 1, 0, 32'h6000_1000, 0, "R4 user store read-only");
    check(fsr_rdata === 8'h8B, "R9 overflow", 32'(fsr_rdata), 32'h8B);
    do_req(1, 0, 0, 1, 3'd4, 1, 0, 32'h7000_2222, 1, "R10 fault with read");
    check(fsr_rdata === 8'h0A, "R10 fault during read no overflow", 32'(fsr_rdata), 32'h0A);
    do_req(0, 0, 0, 0, 3'd0, 0, 0, 32'h0, 1, "R10 idle read");
    do_req(1, 1, 1, 0, 3'd7, 1, 0, 32'h8000_0000, 0, "R4 super store+fetch field7");
    do_req(1, 1, 1, 1, 3'd3, 0, 0, 32'h9000_0000, 0, "R6 user store+fetch unmodified");
    do_req(1, 1, 1, 1, 3'd1, 1, 0, 32'h9100_0000, 0, "R4 store+fetch lacks exec");

    for (int i = 0; i < 1500; i++) begin
      do_req(($urandom % 8) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
             3'($urandom % 8), $urandom % 2, ($urandom % 4) == 0,
             $urandom, ($urandom % 4) == 0, "R2 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule